// File: doc/BRIEF.md
# Debug Signal Bank Output Multiplexer

This block lets a lab instrument watch internal signals of a running design through a narrow set of spare package pins. The design presents several groups of internal signals, all of the same width. A control path, which stands in for a scan-chain user register, picks which group reaches the pins. The choice can be changed while the design keeps running, with no reset and no rebuild. The picked group passes through a short chain of flip-flops on the design clock, so the probe adds little to the timing of the user logic. The design clock is driven out beside the data, so the instrument can sample on its falling edge while the data only moves on its rising edge.

A training mode helps the host learn which package pin is wired to which instrument channel. In this mode a single pin carries a toggling pattern and every other pin is held low. The active pin index moves up by one after a fixed dwell and wraps back to zero after the last pin. A timing variant, picked by a parameter, removes the output flip-flops so that routing skew shows on the pins.

Control is run by a mode machine with three named states. `ST_OBSERVE` drives the selected group. `ST_TRAIN` walks the pin pattern. `ST_INVALID` drives zeros because the requested group does not exist. Every transition happens on an *apply* event. An apply with the training bit set goes to `ST_TRAIN` from any state. An apply with the training bit clear goes to `ST_OBSERVE` when the select value is below the group count, and to `ST_INVALID` otherwise. With no apply, the state holds. Reset enters `ST_OBSERVE` with group 0.

Top module: `dbg_bank_mux`

## Requirements
- R1: In `ST_OBSERVE`, the data pins show the selected group exactly PIPE_DEPTH rising edges after the group data was sampled, and every output word comes from a single group only.
- R2: A control write sampled on rising edge k changes the active mode and selection on edge k+3. The output word sampled at edge k+3 still uses the old setting.
- R3: A select value equal to or greater than NUM_BANKS, written with the training bit clear, enters `ST_INVALID`, and the data pins become all zero.
- R4: Entering `ST_INVALID` sets an error flag. The flag stays set through later valid selections and training, and only reset clears it.
- R5: In `ST_TRAIN`, at most one data bit is high in any word. The active bit is high in the first word after entry and toggles on every clock after that.
- R6: The active training pin starts at index 0 and moves to the next index every DWELL clocks. After index BANK_W-1 it wraps to 0.
- R7: A write with the training bit clear leaves `ST_TRAIN` and brings back the newly selected group.
- R8: The read-back outputs show the applied select value, the group count, the group width, whether training is on, and the error flag.
- R9: The forwarded debug clock follows the design clock in level, so output data changes only on its rising edge.
- R10: During and after reset, the data pins read zero, the read-back select is 0, and training and error read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Design clock; drives the capture and the output flops |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_data_i | input | NUM_BANKS*BANK_W | All groups packed together, group b at bits [b*BANK_W +: BANK_W] |
| ctrl_wr_i | input | 1 | One-cycle write strobe for the control register |
| ctrl_sel_i | input | 6 | Requested group index, 0 to 63 |
| ctrl_train_i | input | 1 | 1 requests training mode; the select field is then ignored |
| dbg_data_o | output | BANK_W | Data to the debug pins |
| dbg_clk_o | output | 1 | Forwarded copy of the design clock |
| rb_sel_o | output | 6 | Read-back: applied select value |
| rb_banks_o | output | 7 | Read-back: NUM_BANKS |
| rb_width_o | output | 8 | Read-back: BANK_W |
| rb_train_o | output | 1 | Read-back: 1 while in `ST_TRAIN` |
| rb_err_o | output | 1 | Read-back: sticky error flag for an out-of-range select |

## Verification
The bench builds the block with five groups of eight bits, a three-stage pipeline and a dwell of four clocks. An odd group count that does not fill the six-bit select field lets the bench write both the last real group (4) and select values beyond it (7). The short dwell makes the walk cover all eight pins and wrap back to pin 0 inside a few dozen clocks. A bench model predicts the data and read-back outputs one cycle at a time and checks them against the block on every clock.

// File: rtl/dbg_mux_pkg.sv
package dbg_mux_pkg;

    // Width of the control select field (covers up to 64 groups)
    localparam int SEL_BITS = 6;

    typedef enum logic [1:0] {
        ST_OBSERVE = 2'd0,
        ST_TRAIN   = 2'd1,
        ST_INVALID = 2'd2
    } mode_e;

endpackage

// File: rtl/dbg_ctrl_sync.sv
// Holds a written control value and hands it to the design clock domain
// through a toggle that passes a two-flop synchronizer.
module dbg_ctrl_sync
    import dbg_mux_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_i,
    input  logic [SEL_BITS-1:0] sel_i,
    input  logic                train_i,
    output logic                apply_o,
    output logic [SEL_BITS-1:0] sel_o,
    output logic                train_o
);

    logic [SEL_BITS-1:0] hold_sel;
    logic                hold_train;
    logic                req_tog;
    logic                sync_a;
    logic                sync_b;
    logic                sync_c;

    // Hold register: written by the control side, then kept stable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_sel   <= '0;
            hold_train <= 1'b0;
            req_tog    <= 1'b0;
        end else if (wr_i) begin
            hold_sel   <= sel_i;
            hold_train <= train_i;
            req_tog    <= ~req_tog;
        end
    end

    // Resynchronizer and edge detector
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_a <= 1'b0;
            sync_b <= 1'b0;
            sync_c <= 1'b0;
        end else begin
            sync_a <= req_tog;
            sync_b <= sync_a;
            sync_c <= sync_b;
        end
    end

    assign apply_o = sync_b ^ sync_c;
    assign sel_o   = hold_sel;
    assign train_o = hold_train;

    // R2: a single write produces a single apply pulse
    a_r2_apply_single: assert property (@(posedge clk) disable iff (!rst_n)
        apply_o |=> !apply_o);

endmodule

// File: rtl/dbg_mode_fsm.sv
// Mode machine: observe / train / invalid, sticky error, pin-walk generator.
module dbg_mode_fsm
    import dbg_mux_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 16,
    parameter int DWELL     = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                apply_i,
    input  logic [SEL_BITS-1:0] req_sel_i,
    input  logic                req_train_i,
    output mode_e               state_o,
    output logic [SEL_BITS-1:0] act_sel_o,
    output logic                err_o,
    output logic [BANK_W-1:0]   train_word_o
);

    localparam int PIN_W = (BANK_W > 1) ? $clog2(BANK_W) : 1;
    localparam int CNT_W = (DWELL > 1) ? $clog2(DWELL) : 1;
    localparam logic [PIN_W-1:0] LAST_PIN  = PIN_W'(BANK_W - 1);
    localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(DWELL - 1);
    localparam logic [SEL_BITS:0] BANK_LIM = (SEL_BITS+1)'(NUM_BANKS);

    mode_e            state_q;
    mode_e            state_d;
    logic             sel_ok;
    logic [PIN_W-1:0] pin_q;
    logic [CNT_W-1:0] cnt_q;
    logic             phase_q;

    assign sel_ok = ({1'b0, req_sel_i} < BANK_LIM);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (apply_i) begin
            if (req_train_i)
                state_d = ST_TRAIN;
            else if (sel_ok)
                state_d = ST_OBSERVE;
            else
                state_d = ST_INVALID;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_OBSERVE;
        else
            state_q <= state_d;
    end

    // Selection and sticky error
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_sel_o <= '0;
            err_o     <= 1'b0;
        end else if (apply_i && !req_train_i) begin
            act_sel_o <= req_sel_i;
            if (!sel_ok)
                err_o <= 1'b1;
        end
    end

    // Pin walk counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q   <= '0;
            cnt_q   <= '0;
            phase_q <= 1'b1;
        end else if (apply_i && req_train_i) begin
            pin_q   <= '0;
            cnt_q   <= '0;
            phase_q <= 1'b1;
        end else if (state_q == ST_TRAIN) begin
            phase_q <= ~phase_q;
            if (cnt_q == LAST_CNT) begin
                cnt_q <= '0;
                pin_q <= (pin_q == LAST_PIN) ? '0 : pin_q + 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Output process
    always_comb begin
        train_word_o = '0;
        unique case (state_q)
            ST_TRAIN:   train_word_o[pin_q] = phase_q;
            ST_OBSERVE: train_word_o = '0;
            ST_INVALID: train_word_o = '0;
            default:    train_word_o = '0;
        endcase
    end

    assign state_o = state_q;

    // R5: at most one pin is driven during training
    a_r5_single_pin: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(train_word_o));
    // R6: the walk index never leaves the pin range
    a_r6_pin_range: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, pin_q} <= {1'b0, LAST_PIN}));
    // R4: the error flag never falls outside reset
    a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

endmodule

// File: rtl/dbg_out_pipe.sv
// Output register chain, or a bypass for the timing variant.
module dbg_out_pipe #(
    parameter int WIDTH  = 16,
    parameter int DEPTH  = 3,
    parameter bit BYPASS = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    generate
        if (BYPASS || DEPTH < 1) begin : g_bypass
            assign q_o = d_i;
        end else begin : g_pipe
            logic [WIDTH-1:0] stage_q [DEPTH];
            for (genvar s = 0; s < DEPTH; s++) begin : g_stage
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)
                        stage_q[s] <= '0;
                    else if (s == 0)
                        stage_q[s] <= d_i;
                    else
                        stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
                end
            end
            assign q_o = stage_q[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/dbg_bank_mux.sv
module dbg_bank_mux
    import dbg_mux_pkg::*;
#(
    parameter int NUM_BANKS  = 4,
    parameter int BANK_W     = 16,
    parameter int PIPE_DEPTH = 3,
    parameter int DWELL      = 16,
    parameter bit ASYNC_MODE = 1'b0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_BANKS*BANK_W-1:0] bank_data_i,
    input  logic                        ctrl_wr_i,
    input  logic [5:0]                  ctrl_sel_i,
    input  logic                        ctrl_train_i,
    output logic [BANK_W-1:0]           dbg_data_o,
    output logic                        dbg_clk_o,
    output logic [5:0]                  rb_sel_o,
    output logic [6:0]                  rb_banks_o,
    output logic [7:0]                  rb_width_o,
    output logic                        rb_train_o,
    output logic                        rb_err_o
);

    logic                apply;
    logic [SEL_BITS-1:0] req_sel;
    logic                req_train;
    mode_e               state;
    logic [SEL_BITS-1:0] act_sel;
    logic                err;
    logic [BANK_W-1:0]   train_word;
    logic [BANK_W-1:0]   pick_word;

    dbg_ctrl_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (ctrl_wr_i),
        .sel_i   (ctrl_sel_i),
        .train_i (ctrl_train_i),
        .apply_o (apply),
        .sel_o   (req_sel),
        .train_o (req_train)
    );

    dbg_mode_fsm #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W),
        .DWELL     (DWELL)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .apply_i      (apply),
        .req_sel_i    (req_sel),
        .req_train_i  (req_train),
        .state_o      (state),
        .act_sel_o    (act_sel),
        .err_o        (err),
        .train_word_o (train_word)
    );

    // Group selector: one whole group, training word, or zeros
    always_comb begin
        pick_word = '0;
        unique case (state)
            ST_OBSERVE: begin
                for (int b = 0; b < NUM_BANKS; b++) begin
                    if (act_sel == SEL_BITS'(b))
                        pick_word = bank_data_i[b*BANK_W +: BANK_W];
                end
            end
            ST_TRAIN:   pick_word = train_word;
            ST_INVALID: pick_word = '0;
            default:    pick_word = '0;
        endcase
    end

    dbg_out_pipe #(
        .WIDTH  (BANK_W),
        .DEPTH  (PIPE_DEPTH),
        .BYPASS (ASYNC_MODE)
    ) u_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pick_word),
        .q_o   (dbg_data_o)
    );

    assign dbg_clk_o  = clk;
    assign rb_sel_o   = act_sel;
    assign rb_banks_o = 7'(NUM_BANKS);
    assign rb_width_o = 8'(BANK_W);
    assign rb_train_o = (state == ST_TRAIN);
    assign rb_err_o   = err;

    // R3: the invalid state always comes with the error flag
    a_r3_invalid_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INVALID) |-> err);
    // R8: the training read-back rises only after an apply
    a_r8_train_on_apply: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rb_train_o) |-> $past(apply));

endmodule

// File: tb/dbg_bank_mux_test.sv
`timescale 1ns/1ps
module dbg_bank_mux_test;

    localparam int NB = 5;
    localparam int W  = 8;
    localparam int P  = 3;
    localparam int D  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB*W-1:0] bank_data = '0;
    logic          ctrl_wr = 1'b0;
    logic [5:0]    ctrl_sel = '0;
    logic          ctrl_train = 1'b0;
    logic [W-1:0]  dbg_data;
    logic          dbg_clk;
    logic [5:0]    rb_sel;
    logic [6:0]    rb_banks;
    logic [7:0]    rb_width;
    logic          rb_train;
    logic          rb_err;

    int n_tests = 0;
    int n_fail  = 0;
    string tag = "R10";
    bit done = 0;

    always #4 clk = ~clk;

    dbg_bank_mux #(.NUM_BANKS(NB), .BANK_W(W), .PIPE_DEPTH(P), .DWELL(D)) uut (
        .clk(clk), .rst_n(rst_n), .bank_data_i(bank_data),
        .ctrl_wr_i(ctrl_wr), .ctrl_sel_i(ctrl_sel), .ctrl_train_i(ctrl_train),
        .dbg_data_o(dbg_data), .dbg_clk_o(dbg_clk),
        .rb_sel_o(rb_sel), .rb_banks_o(rb_banks), .rb_width_o(rb_width),
        .rb_train_o(rb_train), .rb_err_o(rb_err)
    );

    // ---------------- reference model ----------------
    logic [W-1:0] q[$];
    logic [W-1:0] m_out;
    int   m_mode;          // 0 observe, 1 train, 2 invalid
    int   m_sel;
    bit   m_err;
    int   m_n;
    bit   p_valid;
    int   p_cnt;
    int   p_sel;
    bit   p_train;

    function automatic logic [W-1:0] model_word();
        logic [W-1:0] w = '0;
        if (m_mode == 0) w = bank_data[m_sel*W +: W];
        else if (m_mode == 1) w[(m_n / D) % W] = ((m_n % 2) == 0);
        return w;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.delete();
            for (int i = 0; i < P-1; i++) q.push_back('0);
            m_out = '0; m_mode = 0; m_sel = 0; m_err = 0; m_n = 0;
            p_valid = 0; p_cnt = 0; p_sel = 0; p_train = 0;
        end else begin
            q.push_back(model_word());
            m_out = q.pop_front();
            if (m_mode == 1) m_n++;
            if (p_valid) begin
                p_cnt--;
                if (p_cnt == 0) begin
                    p_valid = 0;
                    if (p_train) begin
                        m_mode = 1; m_n = 0;
                    end else begin
                        m_sel = p_sel;
                        if (p_sel < NB) m_mode = 0;
                        else begin m_mode = 2; m_err = 1; end
                    end
                end
            end
            if (ctrl_wr) begin
                p_valid = 1; p_cnt = 3; p_sel = ctrl_sel; p_train = ctrl_train;
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // compare on every falling edge
    always @(negedge clk) begin
        if (!done) begin
            chk(tag, 64'(dbg_data), 64'(m_out));
            chk("R8", {rb_sel, rb_banks, rb_width, rb_train, rb_err},
                {6'(m_sel), 7'(NB), 8'(W), (m_mode == 1), m_err});
            chk("R9", 64'(dbg_clk), 64'(0));
            bank_data <= {$urandom, $urandom};
        end
    end

    task automatic wr_ctrl(input int sel, input bit tr);
        @(negedge clk);
        ctrl_sel = 6'(sel); ctrl_train = tr; ctrl_wr = 1'b1;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        tag = "R10";
        run(3);
        chk("R10", {dbg_data, rb_sel, rb_train, rb_err}, '0);
        @(negedge clk); rst_n = 1'b1;
        tag = "R1";  run(10);
        @(posedge clk); #1; chk("R9", 64'(dbg_clk), 64'(1));
        tag = "R2";  wr_ctrl(3, 0); run(10);
        tag = "R1";  wr_ctrl(4, 0); run(8);
        tag = "R3";  wr_ctrl(7, 0); run(8);
        chk("R3", 64'(dbg_data), 64'(0));
        chk("R4", 64'(rb_err), 64'(1));
        tag = "R4";  wr_ctrl(1, 0); run(8);
        chk("R4", 64'(rb_err), 64'(1));
        tag = "R5";  wr_ctrl(0, 1); run(12);
        tag = "R6";  run(2*W*D + 6);
        chk("R5", 64'(rb_train), 64'(1));
        tag = "R7";  wr_ctrl(2, 0); run(10);
        chk("R7", 64'(rb_train), 64'(0));
        finish_run();
    end

endmodule